// File: doc/BRIEF.md
# USB Device Endpoint Interrupt Aggregator

This block gathers per-endpoint event pulses coming from a USB device protocol engine and folds them into a compact interrupt picture for firmware. Four kinds of event are tracked: a transfer finished with an ACK on a non-zero endpoint, a NAK answered on a non-zero endpoint, a zero-length packet received during a control data stage, and a start-of-frame marker. The first three also record which endpoint was involved, in a detail register per event kind. Frame markers arrive every millisecond at full speed and every 125 µs at high speed. This block only flags them.

Firmware reaches the block through a small word-addressed register bus. It reads the summary word, reads the three detail words and the NAK mask, and clears flags by writing ones. A summary flag that has a detail register behind it drops in either of two cases: firmware writes a one to the flag itself, or firmware writes ones that cover every bit currently set in the detail register. Reporting of NAKs stays off for every endpoint until firmware clears that endpoint's mask bit. A single registered interrupt line is raised while any summary flag is set.

Top module: `usb_evt_irq`

## Requirements
- R1: After reset, the summary, done-detail, zero-length-detail and NAK-detail words read 0, the NAK mask reads 0xF and `irqOut` is 0.
- R2: `evAck` with `evEp` not 0 sets done-detail bit `evEp` and summary bit 6. `evAck` with `evEp` = 0 changes no register.
- R3: Writing a word with bit 6 set to the summary (offset 0x00) clears summary bit 6 and leaves the done detail as it is. A write to the done detail (offset 0x04) clears each bit written as 1. Summary bit 6 also clears when that write covers every bit that was set, and stays set when some set bit was left uncovered.
- R4: `evZlp` with `zlpStatus` = 0 (data stage) sets summary bit 3 and zero-length-detail bit `evEp`, endpoint 0 included. With `zlpStatus` = 1 (status stage) it changes no register.
- R5: The zero-length detail (offset 0x08) and summary bit 3 are cleared by the same two rules as in R3, using summary bit 3.
- R6: `evSof` sets summary bit 4. Only a summary write with bit 4 = 1 clears it, and writes to detail words leave it set.
- R7: `evNak` sets summary bit 7 and NAK-detail bit `evEp` only when `evEp` is not 0 and NAK-mask bit `evEp` is 0. The mask (offset 0x10, bits 3:0, one per endpoint) is loaded by a write.
- R8: The NAK detail (offset 0x0C) and summary bit 7 are cleared by the same two rules as in R3, using summary bit 7.
- R9: When an event and a clearing write hit the same flag or detail bit in one cycle, the bit ends up set.
- R10: `irqOut` is 1 exactly in the cycle after a cycle in which at least one summary bit is set.
- R11: A read (`busSel`=1, `busWr`=0) puts the addressed word on `busRdata` one cycle later, and the value stays there until the next read. Summary bits other than 3, 4, 6 and 7 read 0. Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evAck | input | 1 | One-cycle pulse: transaction completed with ACK |
| evNak | input | 1 | One-cycle pulse: NAK sent |
| evZlp | input | 1 | One-cycle pulse: zero-length data received |
| zlpStatus | input | 1 | Qualifies `evZlp`: 1 = status stage, 0 = data stage |
| evSof | input | 1 | One-cycle pulse: start of frame received |
| evEp | input | 2 | Endpoint number for `evAck`, `evNak`, `evZlp` |
| busSel | input | 1 | Register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach from the ports is a collision between an event and a clearing write on the same flag. A second hard case is a detail write that covers only some of the set bits, so the summary flag must stay up. To get there the bench first builds up several endpoints' bits in a detail register. It then clears them in two partial writes, and it also drives an event pulse in the same cycle as the bus write that would clear its flag. A cycle-accurate model in the bench predicts every read word and the interrupt line, so a late or wrong clear shows up at once.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int LANES     = 3;
  localparam int LANE_DONE = 0;
  localparam int LANE_ZLP  = 1;
  localparam int LANE_NAK  = 2;

  // bit positions firmware decodes in the summary word
  localparam int SUM_ZLP_POS  = 3;
  localparam int SUM_SOF_POS  = 4;
  localparam int SUM_DONE_POS = 6;
  localparam int SUM_NAK_POS  = 7;

  // packed summary flag vector order
  localparam int FLAG_ZLP  = 0;
  localparam int FLAG_SOF  = 1;
  localparam int FLAG_DONE = 2;
  localparam int FLAG_NAK  = 3;
  localparam int FLAGS     = 4;

  localparam int RD_IDX_W = 3;
  localparam logic [RD_IDX_W-1:0] RD_NONE = 3'd5;

  function automatic int lanePos(input int lane);
    case (lane)
      LANE_DONE: return SUM_DONE_POS;
      LANE_ZLP:  return SUM_ZLP_POS;
      default:   return SUM_NAK_POS;
    endcase
  endfunction

  typedef struct packed {
    logic [LANES-1:0]    laneSet;
    logic [LANES-1:0]    laneWr;
    logic                sumWr;
    logic                maskWr;
    logic                sofSet;
    logic                rdEn;
    logic [RD_IDX_W-1:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/usbirq_lane.sv
module usbirq_lane #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setHit,
  input  logic [NUM_EP-1:0] epOneHot,
  input  logic              sumClr,
  input  logic              detWr,
  input  logic [NUM_EP-1:0] wEp,
  output logic [NUM_EP-1:0] detQ,
  output logic              sumQ
);
  logic [NUM_EP-1:0] detKeep;
  logic              clrByDet;

  always_comb begin
    detKeep  = detWr ? (detQ & ~wEp) : detQ;
    clrByDet = detWr && (detKeep == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      detQ <= '0;
      sumQ <= 1'b0;
    end else begin
      detQ <= detKeep | (setHit ? epOneHot : '0);
      if (setHit)                  sumQ <= 1'b1;
      else if (sumClr || clrByDet) sumQ <= 1'b0;
    end
  end
endmodule

// File: rtl/usbirq_ctrl.sv
module usbirq_ctrl
  import usbirq_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 5,
  localparam int EP_W  = $clog2(NUM_EP),
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evAck,
  input  logic              evNak,
  input  logic              evZlp,
  input  logic              zlpStatus,
  input  logic              evSof,
  input  logic [EP_W-1:0]   evEp,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NUM_EP-1:0] maskQ,
  input  logic [FLAGS-1:0]  sumFlags,
  output strobe_t           stb,
  output logic [NUM_EP-1:0] epOneHot,
  output logic              irqOut
);
  logic [WORD_W-1:0] wordIdx;
  logic              aligned, wrEn, epNonZero;

  always_comb begin
    wordIdx   = busAddr[ADDR_W-1:2];
    aligned   = (busAddr[1:0] == 2'b00);
    wrEn      = busSel && busWr && aligned;
    epNonZero = (evEp != '0);
    epOneHot  = NUM_EP'(1) << evEp;

    stb = '0;
    stb.sumWr           = wrEn && (wordIdx == WORD_W'(0));
    stb.laneWr[LANE_DONE] = wrEn && (wordIdx == WORD_W'(1));
    stb.laneWr[LANE_ZLP]  = wrEn && (wordIdx == WORD_W'(2));
    stb.laneWr[LANE_NAK]  = wrEn && (wordIdx == WORD_W'(3));
    stb.maskWr          = wrEn && (wordIdx == WORD_W'(4));

    stb.laneSet[LANE_DONE] = evAck && epNonZero;
    stb.laneSet[LANE_ZLP]  = evZlp && !zlpStatus;
    stb.laneSet[LANE_NAK]  = evNak && epNonZero && !maskQ[evEp];
    stb.sofSet             = evSof;

    stb.rdEn  = busSel && !busWr;
    stb.rdIdx = (aligned && wordIdx <= WORD_W'(4)) ? RD_IDX_W'(wordIdx) : RD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |sumFlags;
  end
endmodule

// File: rtl/usbirq_dp.sv
module usbirq_dp
  import usbirq_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [NUM_EP-1:0] epOneHot,
  input  logic [DATA_W-1:0] busWdata,
  output logic [NUM_EP-1:0] maskQ,
  output logic [FLAGS-1:0]  sumFlags,
  output logic [DATA_W-1:0] busRdata
);
  logic [NUM_EP-1:0] det [LANES];
  logic [LANES-1:0]  laneSum;
  logic              sofQ;
  logic [DATA_W-1:0] rdNext;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int POS = lanePos(g);
    usbirq_lane #(.NUM_EP(NUM_EP)) i_lane (
      .clk      (clk),
      .rstN     (rstN),
      .setHit   (stb.laneSet[g]),
      .epOneHot (epOneHot),
      .sumClr   (stb.sumWr && busWdata[POS]),
      .detWr    (stb.laneWr[g]),
      .wEp      (busWdata[NUM_EP-1:0]),
      .detQ     (det[g]),
      .sumQ     (laneSum[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sofQ  <= 1'b0;
      maskQ <= '1;
    end else begin
      if (stb.sofSet)                          sofQ <= 1'b1;
      else if (stb.sumWr && busWdata[SUM_SOF_POS]) sofQ <= 1'b0;
      if (stb.maskWr) maskQ <= busWdata[NUM_EP-1:0];
    end
  end

  always_comb begin
    sumFlags            = '0;
    sumFlags[FLAG_ZLP]  = laneSum[LANE_ZLP];
    sumFlags[FLAG_SOF]  = sofQ;
    sumFlags[FLAG_DONE] = laneSum[LANE_DONE];
    sumFlags[FLAG_NAK]  = laneSum[LANE_NAK];

    rdNext = '0;
    case (stb.rdIdx)
      3'd0: begin
        rdNext[SUM_ZLP_POS]  = sumFlags[FLAG_ZLP];
        rdNext[SUM_SOF_POS]  = sumFlags[FLAG_SOF];
        rdNext[SUM_DONE_POS] = sumFlags[FLAG_DONE];
        rdNext[SUM_NAK_POS]  = sumFlags[FLAG_NAK];
      end
      3'd1: rdNext[NUM_EP-1:0] = det[LANE_DONE];
      3'd2: rdNext[NUM_EP-1:0] = det[LANE_ZLP];
      3'd3: rdNext[NUM_EP-1:0] = det[LANE_NAK];
      3'd4: rdNext[NUM_EP-1:0] = maskQ;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdNext;
  end
endmodule

// File: rtl/usb_evt_irq.sv
module usb_evt_irq
  import usbirq_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int EP_W  = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evAck,
  input  logic              evNak,
  input  logic              evZlp,
  input  logic              zlpStatus,
  input  logic              evSof,
  input  logic [EP_W-1:0]   evEp,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  strobe_t           stb;
  logic [NUM_EP-1:0] epOneHot;
  logic [NUM_EP-1:0] maskQ;
  logic [FLAGS-1:0]  sumFlags;

  usbirq_ctrl #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .evAck(evAck), .evNak(evNak), .evZlp(evZlp),
    .zlpStatus(zlpStatus), .evSof(evSof), .evEp(evEp), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .maskQ(maskQ), .sumFlags(sumFlags),
    .stb(stb), .epOneHot(epOneHot), .irqOut(irqOut)
  );

  usbirq_dp #(.NUM_EP(NUM_EP), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .epOneHot(epOneHot),
    .busWdata(busWdata), .maskQ(maskQ), .sumFlags(sumFlags),
    .busRdata(busRdata)
  );
endmodule

// File: rtl/usbirq_chk.sv
module usbirq_chk
  import usbirq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int EP_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              evAck,
  input logic              evNak,
  input logic              evZlp,
  input logic              zlpStatus,
  input logic              evSof,
  input logic [EP_W-1:0]   evEp,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic [FLAGS-1:0]  sumFlags
);
  logic sofClrWr;
  assign sofClrWr = busSel && busWr && (busAddr == '0) && busWdata[SUM_SOF_POS];

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sumFlags != '0) |=> irqOut);
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sumFlags == '0) |=> !irqOut);
  // R2
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evAck && evEp != '0) |=> sumFlags[FLAG_DONE]);
  // R4
  zlp_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evZlp && zlpStatus && !sumFlags[FLAG_ZLP]) |=> !sumFlags[FLAG_ZLP]);
  // R7
  nak_ep0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evNak && evEp == '0 && !sumFlags[FLAG_NAK]) |=> !sumFlags[FLAG_NAK]);
  // R9
  sof_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    evSof |=> sumFlags[FLAG_SOF]);
  // R6
  sof_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sumFlags[FLAG_SOF] && !sofClrWr) |=> sumFlags[FLAG_SOF]);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |=> $stable(busRdata));
endmodule

bind usb_evt_irq usbirq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EP_W(EP_W)) i_chk (
  .clk(clk), .rstN(rstN), .evAck(evAck), .evNak(evNak), .evZlp(evZlp),
  .zlpStatus(zlpStatus), .evSof(evSof), .evEp(evEp), .busSel(busSel),
  .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .irqOut(irqOut), .sumFlags(sumFlags)
);

// File: tb/test_usb_evt_irq.sv
`timescale 1ns/1ps
module test_usb_evt_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evAck = 0, evNak = 0, evZlp = 0, zlpStatus = 0, evSof = 0;
  logic [1:0]  evEp = '0;
  logic        busSel = 0, busWr = 0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  always #2 clk = ~clk;

  usb_evt_irq i_usb_evt_irq (
    .clk(clk), .rstN(rstN), .evAck(evAck), .evNak(evNak), .evZlp(evZlp),
    .zlpStatus(zlpStatus), .evSof(evSof), .evEp(evEp), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  // behavioural model: lane 0 done, 1 zero-length, 2 NAK
  int    mDet[3] = '{0, 0, 0};
  bit    mSumL[3] = '{0, 0, 0};
  int    lanePosTb[3] = '{6, 3, 7};
  bit    mSof = 0;
  int    mMask = 15;
  int    mRd = 0;
  bit    mIrq = 0;
  string curReq = "R1";
  int    total = 0, bad = 0;
  bit    finished = 0;

  function automatic int modelRead(input int a);
    if ((a & 3) != 0) return 0;
    case (a >> 2)
      0: return (int'(mSumL[1]) << 3) | (int'(mSof) << 4) |
                (int'(mSumL[0]) << 6) | (int'(mSumL[2]) << 7);
      1: return mDet[0];
      2: return mDet[1];
      3: return mDet[2];
      4: return mMask;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    bit rdDone, wr, nIrq;
    int nRd, widx, w, ep, rem;
    bit setL[3];
    rdDone = busSel && !busWr;
    nRd    = rdDone ? modelRead(int'(busAddr)) : mRd;
    nIrq   = mSumL[0] | mSumL[1] | mSumL[2] | mSof;
    wr     = busSel && busWr && (busAddr[1:0] == 2'b00);
    widx   = int'(busAddr) >> 2;
    w      = busWdata;
    ep     = int'(evEp);
    setL[0] = evAck && ep != 0;
    setL[1] = evZlp && !zlpStatus;
    setL[2] = evNak && ep != 0 && mMask[ep] == 1'b0;
    for (int l = 0; l < 3; l++) begin
      if (wr && widx == l + 1) begin
        rem = mDet[l] & ~w & 15;
        if (rem == 0) mSumL[l] = 0;
        mDet[l] = rem;
      end
      if (wr && widx == 0 && w[lanePosTb[l]]) mSumL[l] = 0;
      if (setL[l]) begin
        mDet[l] = mDet[l] | (1 << ep);
        mSumL[l] = 1;
      end
    end
    if (wr && widx == 0 && w[4]) mSof = 0;
    if (evSof) mSof = 1;
    if (wr && widx == 4) mMask = w & 15;
    @(posedge clk);
    #1;
    mRd  = nRd;
    mIrq = nIrq;
    check("R10", int'(irqOut), int'(mIrq));
    if (rdDone) check(curReq, int'(busRdata), mRd);
    @(negedge clk);
    evAck = 0; evNak = 0; evZlp = 0; zlpStatus = 0; evSof = 0; evEp = '0;
    busSel = 0; busWr = 0; busAddr = '0; busWdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rd(input int a);
    busSel = 1; busWr = 0; busAddr = 5'(a);
    step();
  endtask

  task automatic wrReg(input int a, input int d);
    busSel = 1; busWr = 1; busAddr = 5'(a); busWdata = d;
    step();
  endtask

  task automatic readAll();
    for (int a = 0; a <= 16; a += 4) rd(a);
  endtask

  task automatic ev(input bit a, input bit n, input bit z, input bit zs,
                    input bit s, input int ep);
    evAck = a; evNak = n; evZlp = z; zlpStatus = zs; evSof = s; evEp = 2'(ep);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset values
    curReq = "R1"; readAll();
    // R2 done events
    curReq = "R2";
    ev(1, 0, 0, 0, 0, 0); rd(0); rd(4);
    ev(1, 0, 0, 0, 0, 2); ev(1, 0, 0, 0, 0, 1); idle(2); rd(0); rd(4);
    // R3 clear rules
    curReq = "R3";
    wrReg(0, 32'h40); rd(0); rd(4);
    ev(1, 0, 0, 0, 0, 3); rd(0);
    wrReg(4, 32'h6); rd(0); rd(4);
    wrReg(4, 32'h8); rd(0); rd(4);
    // R4 zero-length in status vs data stage
    curReq = "R4";
    ev(0, 0, 1, 1, 0, 1); rd(0); rd(8);
    ev(0, 0, 1, 0, 0, 0); ev(0, 0, 1, 0, 0, 2); rd(0); rd(8);
    // R5 zero-length clears
    curReq = "R5";
    wrReg(8, 32'h1); rd(0); rd(8);
    wrReg(0, 32'h08); rd(0); rd(8);
    wrReg(8, 32'h4); rd(0); rd(8);
    // R6 frame marker
    curReq = "R6";
    ev(0, 0, 0, 0, 1, 0); idle(1);
    wrReg(4, 32'hF); wrReg(8, 32'hF); wrReg(0, 32'hCF); rd(0);
    wrReg(0, 32'h10); rd(0);
    // R7 NAK masking
    curReq = "R7";
    ev(0, 1, 0, 0, 0, 1); rd(0); rd(12);
    wrReg(16, 32'h4); rd(16);
    ev(0, 1, 0, 0, 0, 0); ev(0, 1, 0, 0, 0, 2); rd(0); rd(12);
    ev(0, 1, 0, 0, 0, 1); ev(0, 1, 0, 0, 0, 3); rd(0); rd(12);
    // R8 NAK clears
    curReq = "R8";
    wrReg(0, 32'h80); rd(0); rd(12);
    ev(0, 1, 0, 0, 0, 3); wrReg(12, 32'h2); rd(0); rd(12);
    wrReg(12, 32'h8); rd(0); rd(12);
    // R9 event beats same-cycle clear
    curReq = "R9";
    evSof = 1; busSel = 1; busWr = 1; busAddr = 5'h0; busWdata = 32'h10; step();
    rd(0);
    evAck = 1; evEp = 2'd1; busSel = 1; busWr = 1; busAddr = 5'h4; busWdata = 32'h2; step();
    rd(0); rd(4);
    evNak = 1; evEp = 2'd1; busSel = 1; busWr = 1; busAddr = 5'h0; busWdata = 32'hFF; step();
    rd(0); rd(12);
    // R10 interrupt line tracks summary with one cycle lag
    curReq = "R10";
    wrReg(0, 32'hFF); idle(3);
    ev(0, 0, 1, 0, 0, 3); idle(2); wrReg(0, 32'h08); idle(2);
    // R11 unmapped, misaligned, hold
    curReq = "R11";
    rd(20); rd(28); rd(2);
    wrReg(17, 32'h0); rd(16);
    wrReg(24, 32'hFFFF); readAll(); idle(3); rd(16);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule